// File: doc/BRIEF.md
# Space Vector Dwell-Time Calculator

This block turns a rotating voltage reference into the three times that a space vector modulator needs for each switching period. The reference is set by a frequency word, an amplitude word and a phase offset word. An angle accumulator advances by the frequency word once per switching-period strobe. The current angle selects one of six 60-degree sectors and an angle θ inside that sector.

From θ and the amplitude, the block works out the time to spend on each of the two active vectors that bound the sector. The remaining time of the half period goes to a null vector. A table of sin(x)/sin(60°) values, filled in at elaboration, supplies the two sine terms. Fixed-point multipliers scale them by the half period and the modulation index. When the two active times together exceed the half period, both are shrunk in the same proportion.

All results are registered on the strobe, so downstream PWM logic sees values that stay steady for a whole switching period. The block has no PWM counter, no gate drive and no control loop.

Top module: `svm_dwell_calc`

## Requirements
- R1: While `rst` is high, and until the first strobe after it, `out_valid`, `sector`, `vec_lead`, `vec_lag`, `t_lead`, `t_lag` and `t_null` are all zero, and the angle accumulator is zero.
- R2: `out_valid` is high for exactly the one cycle after each cycle in which `period_stb` is high. Between strobes all result outputs hold their values, even if the command inputs change.
- R3: The angle used at the n-th strobe after reset (n counted from 0) is A = (Σ earlier frequency words + `phase_word`) mod M, with M = 6·2^16. `sector` is floor(A / 2^16) + 1, in the range 1..6. θ = floor((A mod 2^16) / 2^8) · 60°/256.
- R4: With a = `amp_word`/2^15 and H = `half_period`, `t_lead` ≈ H·a·sin(60°−θ)/sin60° and `t_lag` ≈ H·a·sinθ/sin60°, truncated toward zero and within 2 counts.
- R5: When `t_lead` + `t_lag` ≤ H, `t_null` = H − `t_lead` − `t_lag` exactly.
- R6: When the raw active times sum to more than H, `t_null` is 0 and `t_lead` + `t_lag` = H. `t_lead` is H·raw_lead/(raw_lead+raw_lag), within 2 counts.
- R7: `vec_lead` and `vec_lag` give the inverter state (a,b,c) as bits [2:1:0] of the two active vectors bounding the sector. Sector k uses vectors Uk and U(k mod 6 + 1), with U1=100, U2=110, U3=010, U4=011, U5=001, U6=101.
- R8: The accumulator wraps modulo M, so sector 6 is followed by sector 1. Frequency and phase words up to 2^19−1 are reduced modulo M.
- R9: An amplitude word of zero gives `t_lead` = `t_lag` = 0 and `t_null` = H.
- R10: At θ = 0 (sector boundary), `t_lag` is 0 and `t_lead` = floor(H·a) exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_stb | input | 1 | One-cycle pulse at each switching period start |
| freq_word | input | 19 | Angle increment per period, full circle = 6·2^16 |
| phase_word | input | 19 | Angle offset added to the accumulator |
| amp_word | input | 16 | Modulation index, unsigned Q1.15 |
| half_period | input | 16 | Half switching period in time counts |
| out_valid | output | 1 | High for one cycle after each strobe |
| sector | output | 3 | Sector number 1..6 |
| vec_lead | output | 3 | Switching state of the first active vector |
| vec_lag | output | 3 | Switching state of the second active vector |
| t_lead | output | 16 | Dwell time of the first active vector |
| t_lag | output | 16 | Dwell time of the second active vector |
| t_null | output | 16 | Dwell time of the null vector |

## Verification
The bench steps the reference with a frequency word of exactly one sector, so θ is zero and the exact boundary values show whether the table is indexed the wrong way round or the leading and lagging terms are swapped. A design that took the sector from the wrong bits, or that wrapped after sector 6 to anything other than sector 1, shows the wrong sector number and the wrong vector pair in a sweep that passes through the wrap. A frequency word above one full circle catches a single-stage modulo, which would go to sector 7 or 8. Overmodulation runs catch a negative null time that wraps to a large value, and amplitude changes between strobes catch outputs that are not held.

// File: rtl/svm_pkg.sv
package svm_pkg;

    localparam int SUB_W    = 16;
    localparam int THETA_W  = 8;
    localparam int TIME_W   = 16;
    localparam int AMP_W    = 16;
    localparam int AMP_FRAC = 15;
    localparam int RAT_FRAC = 15;

    typedef enum logic [2:0] {
        VEC_NUL_LO = 3'b000,
        VEC_S1     = 3'b100,
        VEC_S2     = 3'b110,
        VEC_S3     = 3'b010,
        VEC_S4     = 3'b011,
        VEC_S5     = 3'b001,
        VEC_S6     = 3'b101,
        VEC_NUL_HI = 3'b111
    } vec_state_e;

    typedef struct packed {
        logic [2:0] num;
        vec_state_e lead;
        vec_state_e lag;
    } sect_info_t;

    // Active vector k (1..6) to its leg pattern
    function automatic vec_state_e active_vec(input logic [2:0] k);
        case (k)
            3'd1:    return VEC_S1;
            3'd2:    return VEC_S2;
            3'd3:    return VEC_S3;
            3'd4:    return VEC_S4;
            3'd5:    return VEC_S5;
            3'd6:    return VEC_S6;
            default: return VEC_NUL_LO;
        endcase
    endfunction

    // Sector index 0..5 to number and bounding vector pair
    function automatic sect_info_t sector_info(input logic [2:0] idx);
        sect_info_t s;
        s.num  = idx + 3'd1;
        s.lead = active_vec(idx + 3'd1);
        s.lag  = active_vec((idx == 3'd5) ? 3'd1 : idx + 3'd2);
        return s;
    endfunction

    // sin(i * 60deg / n) / sin(60deg), scaled by 2^frac, rounded
    function automatic int ratio_q(input int i, input int n, input int frac);
        real pi_v;
        real th;
        real v;
        pi_v = 3.14159265358979323846;
        th   = (pi_v * i) / (3.0 * n);
        v    = ($sin(th) / $sin(pi_v / 3.0)) * (2.0 ** frac) + 0.5;
        return $rtoi(v);
    endfunction

endpackage

// File: rtl/svm_phase_acc.sv
module svm_phase_acc #(
    parameter int SUB_W   = svm_pkg::SUB_W,
    parameter int THETA_W = svm_pkg::THETA_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 advance,
    input  logic [SUB_W+2:0]     freq_word,
    input  logic [SUB_W+2:0]     phase_word,
    output logic [2:0]           sect_idx,
    output logic [THETA_W-1:0]   theta_idx
);
    localparam int ACC_W = SUB_W + 3;
    localparam logic [ACC_W:0] CIRCLE = (ACC_W+1)'(6) << SUB_W;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_next;
    logic [ACC_W-1:0] angle;

    // Reduce a sum below 2*CIRCLE + CIRCLE into the circle
    function automatic logic [ACC_W-1:0] wrap_circle(input logic [ACC_W:0] v);
        logic [ACC_W:0] s1;
        logic [ACC_W:0] s2;
        s1 = (v  >= CIRCLE) ? v  - CIRCLE : v;
        s2 = (s1 >= CIRCLE) ? s1 - CIRCLE : s1;
        return ACC_W'(s2);
    endfunction

    always_comb begin
        acc_next = wrap_circle({1'b0, acc_q} + {1'b0, freq_word});
        angle    = wrap_circle({1'b0, acc_q} + {1'b0, phase_word});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (advance) begin
            acc_q <= acc_next;
        end
    end

    assign sect_idx  = 3'(angle >> SUB_W);
    assign theta_idx = THETA_W'(angle >> (SUB_W - THETA_W));

endmodule

// File: rtl/svm_ratio_rom.sv
module svm_ratio_rom #(
    parameter int THETA_W  = svm_pkg::THETA_W,
    parameter int RAT_FRAC = svm_pkg::RAT_FRAC
) (
    input  logic [THETA_W-1:0]  theta_idx,
    output logic [RAT_FRAC:0]   ratio_lead,
    output logic [RAT_FRAC:0]   ratio_lag
);
    localparam int N     = 1 << THETA_W;
    localparam int RAT_W = RAT_FRAC + 1;

    logic [RAT_W-1:0] table_q [0:N];

    for (genvar i = 0; i <= N; i++) begin : g_entry
        localparam logic [RAT_W-1:0] ENTRY = RAT_W'(svm_pkg::ratio_q(i, N, RAT_FRAC));
        assign table_q[i] = ENTRY;
    end

    // sin(60-theta) reads the table mirrored about 30 degrees
    assign ratio_lead = table_q[(THETA_W+1)'(N) - {1'b0, theta_idx}];
    assign ratio_lag  = table_q[{1'b0, theta_idx}];

endmodule

// File: rtl/svm_dwell_math.sv
module svm_dwell_math #(
    parameter int TIME_W   = svm_pkg::TIME_W,
    parameter int AMP_W    = svm_pkg::AMP_W,
    parameter int AMP_FRAC = svm_pkg::AMP_FRAC,
    parameter int RAT_FRAC = svm_pkg::RAT_FRAC
) (
    input  logic [TIME_W-1:0]  half_period,
    input  logic [AMP_W-1:0]   amp_word,
    input  logic [RAT_FRAC:0]  ratio_lead,
    input  logic [RAT_FRAC:0]  ratio_lag,
    output logic [TIME_W-1:0]  t_lead,
    output logic [TIME_W-1:0]  t_lag,
    output logic [TIME_W-1:0]  t_null
);
    localparam int RAT_W = RAT_FRAC + 1;
    localparam int PW    = TIME_W + AMP_W + RAT_W;
    localparam int SH    = AMP_FRAC + RAT_FRAC;
    localparam int RAW_W = PW - SH;
    localparam int DW    = RAW_W + TIME_W;

    logic [PW-1:0]    scale_h;
    logic [RAW_W-1:0] raw_lead;
    logic [RAW_W-1:0] raw_lag;
    logic [RAW_W:0]   raw_sum;
    logic             over;
    logic [DW-1:0]    num;

    always_comb begin
        scale_h  = PW'(half_period) * PW'(amp_word);
        raw_lead = RAW_W'((scale_h * PW'(ratio_lead)) >> SH);
        raw_lag  = RAW_W'((scale_h * PW'(ratio_lag))  >> SH);
        raw_sum  = (RAW_W+1)'(raw_lead) + (RAW_W+1)'(raw_lag);
        over     = raw_sum > (RAW_W+1)'(half_period);
        num      = DW'(raw_lead) * DW'(half_period);
    end

    always_comb begin
        if (over) begin
            t_lead = TIME_W'(num / DW'(raw_sum));
            t_lag  = half_period - t_lead;
            t_null = '0;
        end else begin
            t_lead = TIME_W'(raw_lead);
            t_lag  = TIME_W'(raw_lag);
            t_null = half_period - t_lead - t_lag;
        end
    end

endmodule

// File: rtl/svm_dwell_calc.sv
module svm_dwell_calc #(
    parameter int SUB_W    = svm_pkg::SUB_W,
    parameter int THETA_W  = svm_pkg::THETA_W,
    parameter int TIME_W   = svm_pkg::TIME_W,
    parameter int AMP_W    = svm_pkg::AMP_W,
    parameter int AMP_FRAC = svm_pkg::AMP_FRAC,
    parameter int RAT_FRAC = svm_pkg::RAT_FRAC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              period_stb,
    input  logic [SUB_W+2:0]  freq_word,
    input  logic [SUB_W+2:0]  phase_word,
    input  logic [AMP_W-1:0]  amp_word,
    input  logic [TIME_W-1:0] half_period,
    output logic              out_valid,
    output logic [2:0]        sector,
    output logic [2:0]        vec_lead,
    output logic [2:0]        vec_lag,
    output logic [TIME_W-1:0] t_lead,
    output logic [TIME_W-1:0] t_lag,
    output logic [TIME_W-1:0] t_null
);
    import svm_pkg::*;

    logic [2:0]          sect_idx;
    logic [THETA_W-1:0]  theta_idx;
    logic [RAT_FRAC:0]   ratio_lead;
    logic [RAT_FRAC:0]   ratio_lag;
    logic [TIME_W-1:0]   t_lead_c;
    logic [TIME_W-1:0]   t_lag_c;
    logic [TIME_W-1:0]   t_null_c;
    sect_info_t          info_c;
    sect_info_t          info_q;

    svm_phase_acc #(.SUB_W(SUB_W), .THETA_W(THETA_W)) u_acc (
        .clk        (clk),
        .rst        (rst),
        .advance    (period_stb),
        .freq_word  (freq_word),
        .phase_word (phase_word),
        .sect_idx   (sect_idx),
        .theta_idx  (theta_idx)
    );

    svm_ratio_rom #(.THETA_W(THETA_W), .RAT_FRAC(RAT_FRAC)) u_rom (
        .theta_idx  (theta_idx),
        .ratio_lead (ratio_lead),
        .ratio_lag  (ratio_lag)
    );

    svm_dwell_math #(
        .TIME_W(TIME_W), .AMP_W(AMP_W), .AMP_FRAC(AMP_FRAC), .RAT_FRAC(RAT_FRAC)
    ) u_math (
        .half_period (half_period),
        .amp_word    (amp_word),
        .ratio_lead  (ratio_lead),
        .ratio_lag   (ratio_lag),
        .t_lead      (t_lead_c),
        .t_lag       (t_lag_c),
        .t_null      (t_null_c)
    );

    assign info_c = sector_info(sect_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            info_q    <= '0;
            t_lead    <= '0;
            t_lag     <= '0;
            t_null    <= '0;
        end else begin
            out_valid <= period_stb;
            if (period_stb) begin
                info_q <= info_c;
                t_lead <= t_lead_c;
                t_lag  <= t_lag_c;
                t_null <= t_null_c;
            end
        end
    end

    assign sector   = info_q.num;
    assign vec_lead = info_q.lead;
    assign vec_lag  = info_q.lag;

endmodule

// File: rtl/svm_dwell_calc_chk.sv
module svm_dwell_calc_chk #(
    parameter int TIME_W = svm_pkg::TIME_W
) (
    input logic              clk,
    input logic              rst,
    input logic              period_stb,
    input logic [TIME_W-1:0] half_period,
    input logic              out_valid,
    input logic [2:0]        sector,
    input logic [2:0]        vec_lead,
    input logic [2:0]        vec_lag,
    input logic [TIME_W-1:0] t_lead,
    input logic [TIME_W-1:0] t_lag,
    input logic [TIME_W-1:0] t_null
);
    p_valid_rise_r2: assert property (@(posedge clk) disable iff (rst)
        period_stb |=> out_valid);

    p_valid_low_r2: assert property (@(posedge clk) disable iff (rst)
        !period_stb |=> !out_valid);

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !period_stb |=> ($stable(t_lead) && $stable(t_lag) && $stable(t_null)
                         && $stable(sector) && $stable(vec_lead)));

    // R5 and R6: the three times always fill the half period
    p_fill_half_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (({1'b0, t_lead} + {1'b0, t_lag} + {1'b0, t_null})
                       == {1'b0, $past(half_period)}));

    p_sector_range_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (sector >= 3'd1 && sector <= 3'd6));

    p_adjacent_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($countones(vec_lead ^ vec_lag) == 1));

endmodule

bind svm_dwell_calc svm_dwell_calc_chk #(.TIME_W(TIME_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .period_stb  (period_stb),
    .half_period (half_period),
    .out_valid   (out_valid),
    .sector      (sector),
    .vec_lead    (vec_lead),
    .vec_lag     (vec_lag),
    .t_lead      (t_lead),
    .t_lag       (t_lag),
    .t_null      (t_null)
);

// File: tb/svm_dwell_calc_tb.sv
`timescale 1ns/1ps
module svm_dwell_calc_tb;

    localparam int M = 6 * 65536;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        period_stb = 1'b0;
    logic [18:0] freq_word = '0;
    logic [18:0] phase_word = '0;
    logic [15:0] amp_word = '0;
    logic [15:0] half_period = '0;
    logic        out_valid;
    logic [2:0]  sector, vec_lead, vec_lag;
    logic [15:0] t_lead, t_lag, t_null;

    int checks = 0;
    int failures = 0;
    int model_acc = 0;
    bit done = 0;

    always #2 clk = ~clk;

    svm_dwell_calc u_dut (
        .clk(clk), .rst(rst), .period_stb(period_stb),
        .freq_word(freq_word), .phase_word(phase_word),
        .amp_word(amp_word), .half_period(half_period),
        .out_valid(out_valid), .sector(sector),
        .vec_lead(vec_lead), .vec_lag(vec_lag),
        .t_lead(t_lead), .t_lag(t_lag), .t_null(t_null)
    );

    function automatic int vec_code(input int k);
        case (k)
            1: return 3'b100;
            2: return 3'b110;
            3: return 3'b010;
            4: return 3'b011;
            5: return 3'b001;
            6: return 3'b101;
            default: return 0;
        endcase
    endfunction

    function automatic real sin_deg(input real d);
        return $sin(d * 3.14159265358979323846 / 180.0);
    endfunction

    task automatic chk(input string req, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic near(input string req, input int act, input int exp);
        int d;
        d = act - exp;
        chk(req, (d <= 2) && (d >= -2), act, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        period_stb = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_acc = 0;
        @(negedge clk);
    endtask

    // One strobe, then check every result against the model
    task automatic run_period(input string req);
        int angle, sec, idx, h, e1, e2;
        real th, a, r1, r2;
        bit over;
        angle = (model_acc + (int'(phase_word) % M)) % M;
        sec   = angle / 65536;
        idx   = (angle % 65536) / 256;
        th    = idx * 60.0 / 256.0;
        a     = amp_word / 32768.0;
        h     = int'(half_period);
        r1    = h * a * sin_deg(60.0 - th) / sin_deg(60.0);
        r2    = h * a * sin_deg(th) / sin_deg(60.0);
        over  = ($floor(r1) + $floor(r2)) > h;
        if (over) begin
            e1 = $rtoi($floor(r1 * h / (r1 + r2)));
            e2 = h - e1;
        end else begin
            e1 = $rtoi($floor(r1));
            e2 = $rtoi($floor(r2));
        end
        period_stb = 1'b1;
        @(negedge clk);
        period_stb = 1'b0;
        chk({req, " R2 valid"}, out_valid == 1'b1, out_valid, 1);
        chk({req, " R3 sector"}, int'(sector) == sec + 1, sector, sec + 1);
        chk({req, " R7 lead"}, int'(vec_lead) == vec_code(sec + 1), vec_lead, vec_code(sec + 1));
        chk({req, " R7 lag"}, int'(vec_lag) == vec_code((sec == 5) ? 1 : sec + 2),
            vec_lag, vec_code((sec == 5) ? 1 : sec + 2));
        near({req, " R4 t_lead"}, t_lead, e1);
        near({req, " R4 t_lag"}, t_lag, e2);
        if (over) begin
            chk({req, " R6 null"}, t_null == 0, t_null, 0);
            chk({req, " R6 fill"}, int'(t_lead) + int'(t_lag) == h, t_lead + t_lag, h);
        end else begin
            chk({req, " R5 null"}, int'(t_null) == h - int'(t_lead) - int'(t_lag),
                t_null, h - int'(t_lead) - int'(t_lag));
        end
        model_acc = (model_acc + (int'(freq_word) % M)) % M;
        @(negedge clk);
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk("R1 valid", out_valid == 0, out_valid, 0);
        chk("R1 sector", sector == 0, sector, 0);
        chk("R1 vecs", {vec_lead, vec_lag} == 0, {vec_lead, vec_lag}, 0);
        chk("R1 times", {t_lead, t_lag, t_null} == 0, t_lead + t_lag + t_null, 0);
    endtask

    task automatic test_sweep();
        do_reset();
        amp_word = 16'd26214; half_period = 16'd1000;
        freq_word = 19'd40000; phase_word = '0;
        for (int i = 0; i < 14; i++) run_period("R3 R8 sweep");
    endtask

    task automatic test_boundary();
        do_reset();
        amp_word = 16'd32768; half_period = 16'd1000;
        freq_word = 19'd65536; phase_word = '0;
        for (int i = 0; i < 7; i++) begin
            run_period("R10 boundary");
            chk("R10 t_lead exact", t_lead == 1000, t_lead, 1000);
            chk("R10 t_lag zero", t_lag == 0, t_lag, 0);
        end
    endtask

    task automatic test_overmod();
        do_reset();
        amp_word = 16'd36045; half_period = 16'd2000;
        freq_word = 19'd10000; phase_word = 19'd20000;
        for (int i = 0; i < 10; i++) run_period("R6 overmod");
    endtask

    task automatic test_zero_amp();
        do_reset();
        amp_word = '0; half_period = 16'd777;
        freq_word = 19'd30000; phase_word = '0;
        for (int i = 0; i < 3; i++) begin
            run_period("R9 zero amp");
            chk("R9 null full", t_null == 777, t_null, 777);
        end
    endtask

    task automatic test_wrap_large();
        do_reset();
        amp_word = 16'd20000; half_period = 16'd5000;
        freq_word = 19'd500000; phase_word = 19'd450000;
        for (int i = 0; i < 8; i++) run_period("R8 large word");
    endtask

    task automatic test_hold();
        logic [15:0] s1, s2, s0;
        logic [2:0]  sc;
        do_reset();
        amp_word = 16'd16000; half_period = 16'd3000;
        freq_word = 19'd50000; phase_word = '0;
        run_period("R2 hold setup");
        s1 = t_lead; s2 = t_lag; s0 = t_null; sc = sector;
        amp_word = 16'd30000; half_period = 16'd100; phase_word = 19'd200000;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R2 valid low", out_valid == 0, out_valid, 0);
            chk("R2 hold lead", t_lead == s1, t_lead, s1);
            chk("R2 hold null", t_null == s0, t_null, s0);
            chk("R2 hold lag", t_lag == s2, t_lag, s2);
            chk("R2 hold sector", sector == sc, sector, sc);
        end
        run_period("R2 after hold");
    endtask

    task automatic test_phase();
        do_reset();
        amp_word = 16'd24000; half_period = 16'd4000;
        freq_word = 19'd0; phase_word = 19'(3 * 65536 + 128 * 256);
        run_period("R3 phase offset");
        chk("R3 phase sector", sector == 4, sector, 4);
        chk("R4 mid-sector equal", t_lead == t_lag, t_lead, t_lag);
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        test_reset();
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_sweep();
        test_boundary();
        test_overmod();
        test_zero_amp();
        test_wrap_large();
        test_hold();
        test_phase();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule